// File: doc/BRIEF.md
# SPI Master Controller with Register Interface

This block is an SPI master with a 32-bit word-addressed register port. Software fills a byte FIFO through the transmit port. A shift engine sends each byte MSB first on `mosi` and clocks it out on `sclk`. For every byte sent, the engine also captures one byte from `miso` and pushes it into a second byte FIFO, which software drains through the receive port. Four active-low select lines come from a control field. The serial clock is the reference clock divided by a power of two. Clock polarity and clock phase can each be set.

The shift engine is a four-state machine:

- **IDLE**: waiting for a byte.
- **LEAD**: first half of a bit.
- **TRAIL**: second half of a bit.
- **DONE**: the received byte is pushed.

The transitions are:

- **start**: IDLE to LEAD, when the controller runs, starting is allowed and the TX FIFO holds data. The transmit byte is popped at this point.
- **sample**: LEAD to TRAIL, when the half-period counter expires. `miso` is shifted in on this transition.
- **next bit**: TRAIL to LEAD, when the counter expires and bits remain. The transmit byte shifts on this transition.
- **last bit**: TRAIL to DONE, when the counter expires after bit 0.
- **finish**: DONE to IDLE, always taken.
- **abort**: any state to IDLE, when the controller stops running.

Top module: `spim_ctrl`

## Requirements
- R1: The registers are at these byte offsets: control 0x00, status 0x04, interrupt-enable 0x08, interrupt-disable 0x0C, mask 0x10, enable 0x14, TX data 0x1C, RX data 0x20. The control register bits are:
  - bit 0: master
  - bit 1: CPOL
  - bit 2: CPHA
  - bits 5:3: baud select
  - bits 13:10: select field
  - bit 14: manual select
  - bit 15: manual start

  After reset, control reads 0x00003C00, status reads 0x00000004, `ss_n` is 4'hF, `sclk` is 0 and `irq` is 0.
- R2: Each byte written to TX data is sent MSB first on `mosi`. For each byte sent, exactly one byte sampled from `miso` (MSB first) is placed in the RX FIFO. RX data returns the received bytes in arrival order.
- R3: While no byte is being shifted, `sclk` rests at the CPOL level. With CPHA=0, `miso` is sampled on the first `sclk` edge of each bit. With CPHA=1, it is sampled on the second edge.
- R4: One `sclk` period lasts `2 << baud` reference clocks (baud 3 gives 16 clocks).
- R5: With manual select (bit 14) set, `ss_n` equals control bits 13:10 on every cycle. Slave n is selected by the pattern "bit n low, all lower bits high". With bit 14 clear, `ss_n` shows the field only while a byte is in flight and is 4'hF otherwise.
- R6: Activity needs enable-register bit 0 and control bit 0. While either is 0, no byte starts. Clearing enable during a byte aborts it: `sclk` returns to idle and no byte reaches the RX FIFO.
- R7: With bit 15 clear, bytes start automatically whenever the TX FIFO holds data. With bit 15 set, nothing starts until a control write with bit 16 set. That write arms sending until the TX FIFO is empty. Bit 16 always reads 0.
- R8: Status bits 2 (TX not full), 3 (TX full), 4 (RX not empty) and 5 (RX full) follow the FIFO levels live. Bit 0 (RX overflow) and bit 6 (TX write dropped) are sticky. Writing 1 to a sticky bit at 0x04 clears it.
- R9: Writing 1s to 0x08 unmasks sources and writing 1s to 0x0C masks them. The mask register (0x10) reads back the unmasked set. `irq` is the OR of status ANDed with the mask.
- R10: Each FIFO holds 128 bytes. A TX write when the TX FIFO is full is dropped and sets status bit 6. A read of an empty RX FIFO returns 0 and changes nothing.
- R11: A byte that completes while the RX FIFO is full is discarded and sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX on the RX address) |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| irq | output | 1 | Interrupt, masked OR of status |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Active-low slave selects |

## Verification
The hardest condition to reach from the ports is a byte completing while the RX FIFO already holds 128 entries. The same run also covers a dropped TX write.

The stimulus disables the controller and writes 129 bytes, so the last one is refused. It clears the sticky flag and enables the controller. It lets 128 bytes fill the RX FIFO and then sends one more, which the FIFO must refuse. A behavioural slave in the bench follows `sclk` on the edges chosen by CPOL/CPHA and records `mosi`. The bench also compares `ss_n` with a model of the control field on every clock.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int ADDR_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL,
        ST_DONE
    } eng_state_t;

    localparam logic [ADDR_W-1:0] A_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] A_STAT = 6'h04;
    localparam logic [ADDR_W-1:0] A_IEN  = 6'h08;
    localparam logic [ADDR_W-1:0] A_IDIS = 6'h0C;
    localparam logic [ADDR_W-1:0] A_MASK = 6'h10;
    localparam logic [ADDR_W-1:0] A_EN   = 6'h14;
    localparam logic [ADDR_W-1:0] A_TXD  = 6'h1C;
    localparam logic [ADDR_W-1:0] A_RXD  = 6'h20;

    localparam int SRC_N = 7;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int DEPTH = 128,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == (PW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (PW+1)'(do_push) - (PW+1)'(do_pop);
        end
    end

    // R10: a push into a full queue leaves the level untouched
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (cnt == $past(cnt)));
    // R10: popping an empty queue leaves it empty
    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int BAUD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              start_ok,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [BAUD_W-1:0] baud,
    input  logic              tx_empty,
    input  logic [7:0]        tx_byte,
    output logic              tx_pop,
    input  logic              miso,
    output logic              rx_push,
    output logic [7:0]        rx_byte,
    output logic              sclk,
    output logic              mosi,
    output logic              busy
);
    localparam int CNT_W = 2 ** BAUD_W;

    eng_state_t      st, nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;
    logic [2:0]       bits_left;
    logic [7:0]       sh_tx, sh_rx;
    logic             tick;

    assign half_m1 = (CNT_W'(1) << baud) - 1'b1;
    assign tick    = (cnt == half_m1);

    always_comb begin
        nxt     = st;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start_ok && !tx_empty) begin
                    nxt    = ST_LEAD;
                    tx_pop = 1'b1;
                end
            end
            ST_LEAD:  if (tick) nxt = ST_TRAIL;
            ST_TRAIL: if (tick) nxt = (bits_left == 3'd0) ? ST_DONE : ST_LEAD;
            ST_DONE: begin
                nxt     = ST_IDLE;
                rx_push = 1'b1;
            end
        endcase
        if (!run) begin
            nxt     = ST_IDLE;
            tx_pop  = 1'b0;
            rx_push = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            bits_left <= '0;
            sh_tx     <= '0;
            sh_rx     <= '0;
        end else begin
            st  <= nxt;
            cnt <= (nxt != st || st == ST_IDLE) ? '0 : cnt + 1'b1;
            if (tx_pop) begin
                sh_tx     <= tx_byte;
                bits_left <= 3'd7;
            end
            if (st == ST_LEAD && tick && run) sh_rx <= {sh_rx[6:0], miso};
            if (st == ST_TRAIL && tick && run && bits_left != 3'd0) begin
                sh_tx     <= {sh_tx[6:0], 1'b0};
                bits_left <= bits_left - 1'b1;
            end
        end
    end

    always_comb begin
        sclk    = cpol ^ ((st == ST_LEAD && cpha) || (st == ST_TRAIL && !cpha));
        mosi    = sh_tx[7];
        busy    = (st != ST_IDLE);
        rx_byte = sh_rx;
    end

    // R6: a stopped controller is back in IDLE on the next cycle
    p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st == ST_IDLE));
    // R7: taking a byte from TX always opens the first bit half
    p_start_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> (st == ST_LEAD));
    // R2: a received byte is handed over only after a completed last bit
    p_push_after_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> ($past(st) == ST_TRAIL));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int BAUD_W     = 3,
    parameter int SS_N       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [SS_N-1:0]   ss_n
);
    localparam int SS_LO = 10;
    localparam int SS_HI = SS_LO + SS_N - 1;

    logic              c_master, c_cpol, c_cpha, c_mcs, c_mstart;
    logic [BAUD_W-1:0] c_baud;
    logic [SS_N-1:0]   c_sel;
    logic              en_q, go_q, ovf_q, drop_q;
    logic [SRC_N-1:0]  mask_q, stat;

    logic       tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0] tx_dout, rx_dout, rx_byte;
    logic       tx_pop, rx_push, busy, run, start_ok;
    logic       wr_ctrl, wr_stat, wr_ien, wr_idis, wr_en, wr_tx, rd_rx;

    assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
    assign wr_stat = bus_wr && bus_addr == A_STAT;
    assign wr_ien  = bus_wr && bus_addr == A_IEN;
    assign wr_idis = bus_wr && bus_addr == A_IDIS;
    assign wr_en   = bus_wr && bus_addr == A_EN;
    assign wr_tx   = bus_wr && bus_addr == A_TXD;
    assign rd_rx   = bus_rd && bus_addr == A_RXD;

    assign run      = en_q && c_master;
    assign start_ok = !c_mstart || go_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_master <= 1'b0;
            c_cpol   <= 1'b0;
            c_cpha   <= 1'b0;
            c_baud   <= '0;
            c_sel    <= '1;
            c_mcs    <= 1'b0;
            c_mstart <= 1'b0;
            en_q     <= 1'b0;
            go_q     <= 1'b0;
            ovf_q    <= 1'b0;
            drop_q   <= 1'b0;
            mask_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                c_master <= bus_wdata[0];
                c_cpol   <= bus_wdata[1];
                c_cpha   <= bus_wdata[2];
                c_baud   <= bus_wdata[3 +: BAUD_W];
                c_sel    <= bus_wdata[SS_HI:SS_LO];
                c_mcs    <= bus_wdata[14];
                c_mstart <= bus_wdata[15];
            end
            if (wr_en) en_q <= bus_wdata[0];
            if (wr_ctrl && bus_wdata[16])  go_q <= 1'b1;
            else if (tx_empty && !busy)    go_q <= 1'b0;
            if (rx_push && rx_full)        ovf_q <= 1'b1;
            else if (wr_stat && bus_wdata[0]) ovf_q <= 1'b0;
            if (wr_tx && tx_full)          drop_q <= 1'b1;
            else if (wr_stat && bus_wdata[6]) drop_q <= 1'b0;
            if (wr_ien)       mask_q <= mask_q | bus_wdata[SRC_N-1:0];
            else if (wr_idis) mask_q <= mask_q & ~bus_wdata[SRC_N-1:0];
        end
    end

    spim_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(wr_tx), .wdata(bus_wdata[7:0]),
        .pop(tx_pop), .rdata(tx_dout), .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_byte),
        .pop(rd_rx), .rdata(rx_dout), .empty(rx_empty), .full(rx_full)
    );

    spim_engine #(.BAUD_W(BAUD_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .run(run), .start_ok(start_ok),
        .cpol(c_cpol), .cpha(c_cpha), .baud(c_baud),
        .tx_empty(tx_empty), .tx_byte(tx_dout), .tx_pop(tx_pop),
        .miso(miso), .rx_push(rx_push), .rx_byte(rx_byte),
        .sclk(sclk), .mosi(mosi), .busy(busy)
    );

    assign stat = {drop_q, rx_full, !rx_empty, tx_full, !tx_full, 1'b0, ovf_q};
    assign irq  = |(stat & mask_q);
    assign ss_n = (c_mcs || busy) ? c_sel : '1;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                A_CTRL: begin
                    bus_rdata[0]           = c_master;
                    bus_rdata[1]           = c_cpol;
                    bus_rdata[2]           = c_cpha;
                    bus_rdata[3 +: BAUD_W] = c_baud;
                    bus_rdata[SS_HI:SS_LO] = c_sel;
                    bus_rdata[14]          = c_mcs;
                    bus_rdata[15]          = c_mstart;
                end
                A_STAT:  bus_rdata[SRC_N-1:0] = stat;
                A_MASK:  bus_rdata[SRC_N-1:0] = mask_q;
                A_EN:    bus_rdata[0] = en_q;
                A_RXD:   bus_rdata[7:0] = rx_empty ? 8'h00 : rx_dout;
                default: bus_rdata = '0;
            endcase
        end
    end

    // R11: the overflow flag rises only when a byte meets a full RX queue
    p_ovf_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(rx_push && rx_full));
    // R3: with no byte in flight the clock rests at the polarity level
    p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == c_cpol));
    // R5: in automatic select mode the lines are released while idle
    p_auto_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_mcs && !busy) |-> (ss_n == '1));
endmodule

// File: tb/spim_ctrl_tb.sv
`timescale 1ns/1ps
module spim_ctrl_tb;
    logic        clk = 0, rst_n = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [5:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        irq, sclk, mosi, miso;
    logic [3:0]  ss_n;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    spim_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    always #4 clk = ~clk;

    // behavioural slave and select-line model
    logic [7:0] s_tx[$];
    logic [7:0] s_rx[$];
    logic [7:0] s_acc = 0;
    int         sb = 0;
    bit         s_on = 0, m_cpol = 0, m_cpha = 0, m_manual = 0;
    logic [3:0] m_sel = 4'hF;
    logic       miso_r = 0;
    logic [31:0] cur_ctrl = 0;
    assign miso = miso_r;

    always @(sclk) begin
        if (s_on && sclk == (m_cpha ? m_cpol : ~m_cpol)) begin
            s_acc = {s_acc[6:0], mosi};
            sb++;
            if (sb == 8) begin
                s_rx.push_back(s_acc);
                sb = 0;
                if (s_tx.size() > 0) void'(s_tx.pop_front());
            end
            miso_r = (s_tx.size() > 0) ? s_tx[0][7-sb] : 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // R5: select lines compared with the model on every clock
    always @(negedge clk) begin
        if (rst_n && m_manual && !done) chk("R5 ss_n per clock", ss_n, m_sel);
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge clk);
        #1;
        if (a == 6'h00) begin
            m_sel = d[13:10]; m_manual = d[14]; m_cpol = d[1]; m_cpha = d[2];
        end
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic cfg(input bit pol, input bit pha, input int baud,
                       input logic [3:0] sel, input bit man, input bit mst);
        s_on = 0;
        cur_ctrl = 32'h1 | (32'(pol) << 1) | (32'(pha) << 2) | (32'(baud) << 3)
                 | (32'(sel) << 10) | (32'(man) << 14) | (32'(mst) << 15);
        wr(6'h00, cur_ctrl);
        sb = 0;
        s_on = 1;
    endtask

    task automatic run_bytes(input int n, input logic [7:0] st, input logic [7:0] sr,
                             input int half, input string req);
        logic [31:0] d;
        s_tx.delete(); s_rx.delete();
        for (int i = 0; i < n; i++) s_tx.push_back(sr ^ 8'(i * 11));
        miso_r = s_tx[0][7];
        for (int i = 0; i < n; i++) wr(6'h1C, 32'(8'(st + i * 37)));
        repeat (n * (16 * half + 2) + 10) @(posedge clk);
        for (int i = 0; i < n; i++) begin
            rd(6'h20, d);
            chk({req, " rx byte"}, d, 32'(sr ^ 8'(i * 11)));
        end
        chk({req, " slave byte count"}, s_rx.size(), n);
        for (int i = 0; i < n && i < s_rx.size(); i++)
            chk({req, " mosi byte"}, s_rx[i], 32'(8'(st + i * 37)));
    endtask

    initial begin
        logic [31:0] d;
        realtime t1, t2;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        @(negedge clk);
        chk("R1 ss_n reset", ss_n, 4'hF);
        chk("R1 sclk reset", sclk, 0);
        chk("R1 irq reset", irq, 0);
        rd(6'h00, d); chk("R1 control reset", d, 32'h3C00);
        rd(6'h04, d); chk("R1 status reset", d, 32'h04);

        // R2 mode 0, fastest rate
        cfg(0, 0, 0, 4'hE, 1, 0);
        wr(6'h14, 1);
        run_bytes(3, 8'hA5, 8'h5A, 1, "R2");

        // R3 other modes and rates
        cfg(1, 0, 1, 4'hD, 1, 0);
        @(negedge clk); chk("R3 idle level cpol1", sclk, 1);
        run_bytes(2, 8'h3C, 8'hC3, 2, "R3 mode2");
        cfg(0, 1, 2, 4'hB, 1, 0);
        @(negedge clk); chk("R3 idle level cpol0", sclk, 0);
        run_bytes(2, 8'h81, 8'h7E, 4, "R3 mode1");
        cfg(1, 1, 0, 4'h7, 1, 0);
        run_bytes(2, 8'hF0, 8'h0F, 1, "R3 mode3");

        // R4 period for baud 3
        cfg(0, 0, 3, 4'hE, 1, 0);
        fork
            run_bytes(1, 8'h55, 8'hAA, 8, "R4");
            begin
                @(posedge sclk); t1 = $realtime;
                @(posedge sclk); t2 = $realtime;
                chk("R4 sclk period clocks", int'((t2 - t1) / 8.0), 16);
            end
        join

        // R5 automatic select mode
        cfg(0, 0, 0, 4'hD, 0, 0);
        @(negedge clk); chk("R5 auto idle released", ss_n, 4'hF);
        s_tx.delete(); s_rx.delete(); s_tx.push_back(8'h11); miso_r = 0;
        wr(6'h1C, 8'h22);
        repeat (4) @(negedge clk);
        chk("R5 auto select in flight", ss_n, 4'hD);
        repeat (30) @(negedge clk);
        chk("R5 auto released after byte", ss_n, 4'hF);
        rd(6'h20, d); chk("R5 auto byte", d, 8'h11);

        // R6 enable gating and abort
        cfg(0, 0, 3, 4'hE, 1, 0);
        wr(6'h14, 0);
        s_tx.delete(); s_rx.delete(); s_tx.push_back(8'h99); miso_r = 1;
        wr(6'h1C, 8'h3C);
        repeat (400) @(posedge clk);
        rd(6'h04, d); chk("R6 disabled no rx", d[4], 0);
        chk("R6 disabled no slave bytes", s_rx.size(), 0);
        wr(6'h14, 1);
        repeat (60) @(posedge clk);
        wr(6'h14, 0);
        repeat (300) @(posedge clk);
        @(negedge clk); chk("R6 abort sclk idle", sclk, 0);
        rd(6'h04, d); chk("R6 abort no rx byte", d[4], 0);
        s_on = 0; sb = 0; s_on = 1;
        wr(6'h14, 1);

        // R7 manual start
        cfg(0, 0, 0, 4'hE, 1, 1);
        s_tx.delete(); s_rx.delete(); s_tx.push_back(8'h66); miso_r = 0;
        wr(6'h1C, 8'h99);
        repeat (100) @(posedge clk);
        rd(6'h04, d); chk("R7 held until go", d[4], 0);
        wr(6'h00, cur_ctrl | 32'h1_0000);
        repeat (40) @(posedge clk);
        rd(6'h00, d); chk("R7 go bit reads 0", d[16], 0);
        rd(6'h20, d); chk("R7 byte after go", d, 8'h66);
        chk("R7 mosi after go", s_rx.size() > 0 ? s_rx[0] : 0, 8'h99);

        // R10/R8/R11 fill both queues
        cfg(0, 0, 0, 4'hE, 1, 0);
        wr(6'h14, 0);
        s_tx.delete(); s_rx.delete();
        for (int i = 0; i < 128; i++) s_tx.push_back(8'(i) ^ 8'h55);
        s_tx.push_back(8'hEE);
        miso_r = s_tx[0][7];
        for (int i = 0; i < 129; i++) wr(6'h1C, 32'(8'(i)));
        rd(6'h04, d); chk("R10 TX full and dropped", d, 32'h48);
        wr(6'h04, 32'h45);
        rd(6'h04, d); chk("R8 sticky cleared, live kept", d, 32'h08);
        wr(6'h14, 1);
        repeat (128 * 18 + 30) @(posedge clk);
        rd(6'h04, d); chk("R8 RX full status", d, 32'h34);
        wr(6'h1C, 8'h77);
        repeat (40) @(posedge clk);
        rd(6'h04, d); chk("R11 overflow flag", d, 32'h35);
        begin
            int bad = 0;
            for (int i = 0; i < 128; i++) begin
                rd(6'h20, d);
                if (d !== 32'(8'(i) ^ 8'h55)) bad++;
            end
            chk("R11 first 128 kept, extra dropped", bad, 0);
        end
        chk("R10 slave saw 129 bytes", s_rx.size(), 129);
        chk("R10 last mosi byte", s_rx.size() == 129 ? s_rx[128] : 0, 8'h77);
        rd(6'h20, d); chk("R10 empty read is zero", d, 0);
        rd(6'h04, d); chk("R10 empty read no effect", d, 32'h05);
        wr(6'h04, 32'h01);
        rd(6'h04, d); chk("R8 overflow cleared", d, 32'h04);

        // R9 interrupt masking
        s_tx.delete(); s_rx.delete(); s_tx.push_back(8'h42); miso_r = 0;
        wr(6'h1C, 8'h24);
        repeat (40) @(posedge clk);
        @(negedge clk); chk("R9 irq masked", irq, 0);
        wr(6'h08, 32'h10);
        @(negedge clk); chk("R9 irq on rx", irq, 1);
        rd(6'h10, d); chk("R9 mask readback", d, 32'h10);
        wr(6'h0C, 32'h10);
        @(negedge clk); chk("R9 irq masked again", irq, 0);
        rd(6'h10, d); chk("R9 mask cleared", d, 0);
        wr(6'h08, 32'h04);
        @(negedge clk); chk("R9 irq on tx not full", irq, 1);
        wr(6'h0C, 32'h7F);
        rd(6'h20, d); chk("R9 rx byte", d, 8'h42);

        repeat (5) @(posedge clk);
        finish_run();
    end
endmodule